// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of every beat in one SDRAM burst, as the column counter inside a memory model or a memory controller would. A one-cycle start pulse captures a start column, a burst length code, an ordering choice and the access direction. From the next cycle on, the block presents one column per clock together with a valid flag. It also raises a flag on the final beat, which a controller can use to begin auto precharge.

Bursts of 1, 2, 4 or 8 beats walk either sequentially, wrapping inside the aligned block, or in interleaved order, with the beat index XORed into the low column bits. A full-page burst steps through the whole 256-column page and only ends on a burst-stop pulse. A burst-stop pulse or a fresh start pulse cuts the current burst short. A single-write flag limits write bursts to one beat and leaves reads at the programmed length.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and after it is released with no start pulse, beatValid and lastBeat are low.
- R2: A start pulse sampled at a clock edge makes beatValid high from that edge on, with colAddr equal to the sampled start column. Later beats follow on consecutive cycles.
- R3: Length code 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. The reserved codes 4, 5 and 6 give a 1-beat burst.
- R4: With typeIlv low and a length L of 2, 4 or 8, beat n has colAddr equal to the start column with its low log2(L) bits replaced by (start + n) mod L. The upper bits stay fixed.
- R5: With typeIlv high (1 = interleaved) and length L of 2, 4 or 8, beat n has colAddr equal to start XOR n. In full-page mode typeIlv has no effect.
- R6: In full-page mode, beat n has colAddr = (start + n) mod 256. Beats continue without end until a burst-stop or start pulse, and lastBeat stays low.
- R7: For lengths 1 to 8, lastBeat is high on the final beat only, and beatValid is low on the following cycle unless a new start was sampled.
- R8: A stopPulse sampled during a burst ends it, and no further beats are produced. When startPulse and stopPulse are sampled together, the start wins.
- R9: A start pulse sampled during an active burst abandons the old burst. Beat 0 of the new burst appears on the next cycle.
- R10: When singleWrite and isWrite are both high at the start pulse, the burst is 1 beat regardless of the length code. Reads (isWrite low) keep the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a burst with the fields below |
| startCol | input | 8 | Start column of the burst |
| lenCode | input | 3 | Burst length code (see R3) |
| typeIlv | input | 1 | 1 = interleaved order, 0 = sequential |
| isWrite | input | 1 | 1 = the burst is a write |
| singleWrite | input | 1 | 1 = writes are limited to one beat |
| stopPulse | input | 1 | Burst stop |
| colAddr | output | 8 | Column address of the current beat |
| beatValid | output | 1 | A beat is presented this cycle |
| lastBeat | output | 1 | Current beat is the final one |

## Verification
The bench builds the block with its default 8-bit column width. This makes the 256-column page real, so a full-page burst started near the top of the page can be followed across the wrap from column 255 to column 0. The same width lets sequential bursts start in the last aligned block (start 0xFF), where the wrap must stay inside the block and never carry into the upper column bits.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic       load;    // capture a new burst
    logic       step;    // advance one beat
    logic       full;    // full-page burst
    logic [1:0] lenLog;  // log2 of burst length (1..8)
  } seqCtl_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startPulse,
  input  logic       stopPulse,
  input  logic [2:0] lenCode,
  input  logic       isWrite,
  input  logic       singleWrite,
  input  logic       isEnd,
  output seqCtl_t    ctl,
  output logic       beatValid,
  output logic       lastBeat
);
  localparam logic [2:0] FULL_CODE = 3'd7;

  logic active;
  logic forceOne;

  always_comb begin
    forceOne   = singleWrite && isWrite;
    ctl.load   = startPulse;
    ctl.step   = active && !startPulse && !stopPulse && !isEnd;
    ctl.full   = !forceOne && (lenCode == FULL_CODE);
    ctl.lenLog = (!forceOne && !lenCode[2]) ? lenCode[1:0] : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          active <= 1'b0;
    else if (startPulse) active <= 1'b1;
    else if (stopPulse)  active <= 1'b0;
    else if (isEnd)      active <= 1'b0;
  end

  assign beatValid = active;
  assign lastBeat  = active && isEnd;

  // R2
  start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> beatValid);
  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopPulse && !startPulse) |=> !beatValid);
  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lastBeat && !startPulse) |=> !beatValid);
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] startCol,
  input  logic             typeIlv,
  input  seqCtl_t          ctl,
  output logic [COL_W-1:0] colAddr,
  output logic             isEnd
);
  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] cntQ;
  logic [1:0]       lenLogQ;
  logic             fullQ;
  logic             ilvQ;
  logic [COL_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseQ   <= '0;
      cntQ    <= '0;
      lenLogQ <= '0;
      fullQ   <= 1'b0;
      ilvQ    <= 1'b0;
    end else if (ctl.load) begin
      baseQ   <= startCol;
      cntQ    <= '0;
      lenLogQ <= ctl.lenLog;
      fullQ   <= ctl.full;
      ilvQ    <= typeIlv;
    end else if (ctl.step) begin
      cntQ    <= cntQ + 1'b1;
    end
  end

  always_comb begin
    mask = (COL_W'(1) << lenLogQ) - COL_W'(1);
    if (fullQ)
      colAddr = baseQ + cntQ;
    else if (ilvQ)
      colAddr = baseQ ^ (cntQ & mask);
    else
      colAddr = (baseQ & ~mask) | ((baseQ + cntQ) & mask);
    isEnd = !fullQ && ((cntQ & mask) == mask);
  end

  // R2
  first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> colAddr == $past(startCol));
  // R6
  full_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && fullQ) |=> colAddr == $past(colAddr) + 1'b1);
  // R4
  lin_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && !fullQ && !ilvQ) |=> (colAddr & ~mask) == ($past(colAddr) & ~mask));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startPulse,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             typeIlv,
  input  logic             isWrite,
  input  logic             singleWrite,
  input  logic             stopPulse,
  output logic [COL_W-1:0] colAddr,
  output logic             beatValid,
  output logic             lastBeat
);
  seqCtl_t ctl;
  logic    isEnd;

  burst_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .stopPulse(stopPulse),
    .lenCode(lenCode), .isWrite(isWrite), .singleWrite(singleWrite),
    .isEnd(isEnd), .ctl(ctl), .beatValid(beatValid), .lastBeat(lastBeat)
  );

  burst_seq_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .startCol(startCol), .typeIlv(typeIlv),
    .ctl(ctl), .colAddr(colAddr), .isEnd(isEnd)
  );
endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startPulse = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       typeIlv = 1'b0;
  logic       isWrite = 1'b0;
  logic       singleWrite = 1'b0;
  logic       stopPulse = 1'b0;
  logic [7:0] colAddr;
  logic       beatValid;
  logic       lastBeat;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] col;
    logic       last;
    string      tag;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .startCol(startCol),
    .lenCode(lenCode), .typeIlv(typeIlv), .isWrite(isWrite),
    .singleWrite(singleWrite), .stopPulse(stopPulse),
    .colAddr(colAddr), .beatValid(beatValid), .lastBeat(lastBeat)
  );

  function automatic logic [7:0] expCol(int base, int lg, bit full, bit ilv, int n);
    int len = 1 << lg;
    if (full) return 8'((base + n) % 256);
    if (ilv)  return 8'(base ^ n);
    return 8'((base - (base % len)) + ((base + n) % len));
  endfunction

  // drive a start pulse (one cycle) and queue `keep` expected beats
  task automatic issue(int col, int code, bit ilv, bit wr, bit sw, int keep,
                       bit stopToo, string tag);
    bit full;
    int lg, n;
    full = (code == 7) && !(sw && wr);
    lg   = (sw && wr) ? 0 : ((code <= 3) ? code : 0);
    n    = full ? keep : (1 << lg);
    if (keep < n) n = keep;
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.col  = expCol(col, lg, full, ilv, i);
      it.last = !full && (i == (1 << lg) - 1);
      it.tag  = tag;
      expQ.push_back(it);
    end
    startPulse = 1'b1; startCol = 8'(col); lenCode = 3'(code);
    typeIlv = ilv; isWrite = wr; singleWrite = sw; stopPulse = stopToo;
    @(negedge clk);
    startPulse = 1'b0; stopPulse = 1'b0;
  endtask

  task automatic stopNow();
    stopPulse = 1'b1;
    @(negedge clk);
    stopPulse = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && beatValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected beat: col=%0h last=%0b expected no beat", colAddr, lastBeat);
      end else begin
        item_t e;
        e = expQ.pop_front();
        if (colAddr !== e.col || lastBeat !== e.last) begin
          bad++;
          $display("FAIL %s col=%0h last=%0b expected col=%0h last=%0b",
                   e.tag, colAddr, lastBeat, e.col, e.last);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 during reset
    total++;
    if (beatValid !== 1'b0 || lastBeat !== 1'b0) begin
      bad++; $display("FAIL R1 valid=%0b last=%0b expected 0 0", beatValid, lastBeat);
    end
    rst_n = 1'b1;
    idle(3);
    total++;
    if (beatValid !== 1'b0 || lastBeat !== 1'b0) begin
      bad++; $display("FAIL R1 after reset valid=%0b last=%0b expected 0 0", beatValid, lastBeat);
    end

    // R4 sequential wrap inside block, R7 last flag
    issue(8'h3E, 2, 0, 0, 0, 99, 0, "R4"); idle(10);
    issue(8'h0D, 3, 0, 0, 0, 99, 0, "R4"); idle(10);
    issue(8'hFF, 1, 0, 0, 0, 99, 0, "R7"); idle(10);
    // R5 interleaved
    issue(8'h15, 3, 1, 0, 0, 99, 0, "R5"); idle(10);
    issue(8'hA6, 2, 1, 0, 0, 99, 0, "R5"); idle(10);
    issue(8'h43, 1, 1, 0, 0, 99, 0, "R5"); idle(10);
    // R3 length codes incl. reserved
    issue(8'h77, 0, 0, 0, 0, 99, 0, "R3"); idle(10);
    issue(8'h21, 5, 0, 0, 0, 99, 0, "R3"); idle(10);
    issue(8'h22, 6, 1, 0, 0, 99, 0, "R3"); idle(10);
    // R6 full page across the wrap, then stop
    issue(8'hF0, 7, 0, 0, 0, 20, 0, "R6"); idle(19); stopNow(); idle(10);
    // R5 interleave ignored in full page
    issue(8'h09, 7, 1, 0, 0, 5, 0, "R5"); idle(4); stopNow(); idle(10);
    // R6 longer full page run (300 beats, covers whole page)
    issue(8'h80, 7, 0, 0, 0, 300, 0, "R6"); idle(299); stopNow(); idle(10);
    // R8 stop mid-burst after 3 beats
    issue(8'h50, 3, 0, 0, 0, 3, 0, "R8"); idle(2); stopNow(); idle(10);
    // R8 start and stop together: start wins
    issue(8'h64, 2, 0, 0, 0, 99, 1, "R8"); idle(10);
    // R9 abort after 2 beats, new burst follows at once
    issue(8'h10, 3, 0, 0, 0, 2, 0, "R9"); idle(1);
    issue(8'hC5, 2, 1, 0, 0, 99, 0, "R9"); idle(10);
    // R9 back-to-back start right on the last beat
    issue(8'h31, 1, 0, 0, 0, 99, 0, "R9"); idle(1);
    issue(8'h32, 1, 0, 0, 0, 99, 0, "R9"); idle(10);
    // R10 single-write mode
    issue(8'h18, 3, 0, 1, 1, 99, 0, "R10"); idle(10);
    issue(8'h18, 3, 0, 0, 1, 99, 0, "R10"); idle(10);
    issue(8'h18, 7, 0, 1, 1, 99, 0, "R10"); idle(10);
    issue(8'h2A, 2, 1, 1, 0, 99, 0, "R10"); idle(10);

    total++;
    if (expQ.size() != 0) begin
      bad++; $display("FAIL R7 missing beats: left=%0d expected 0", expQ.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule